// File: doc/BRIEF.md
# Stacked Interrupt Status Controller

This block gathers interrupt conditions from two sources, a bus-protocol engine and a DMA engine, into status registers that clear when read. Each source has a live status register and a single stacked entry behind it. A condition that arrives while the live register still holds unserviced bits waits in the stack. A clearing read then reloads the live register from the stack, so the status a read leaves behind may still be non-zero.

A summary register shows one pending bit per source. A source is pending when its live register holds at least one bit whose enable is set. The active-low interrupt pin is driven from these pending bits. The protocol source can be masked at the pin without losing its status. An interrupt that already drives the pin when the mask is set keeps driving it until software services it.

Reading the protocol status also sends a one-cycle strobe that clears an external CRC-error flag.

Top module: `stacked_irq_ctrl`

## Requirements
- R1: While rst_ni is low, and after it rises, every status register reads zero, irq_no is high and crc_clr_o is low.
- R2: A condition pulse is recorded in its source's status register whether or not its enable bit is set. A bit with its enable clear raises neither the pending bit nor the pin.
- R3: The summary register at address 0 has the protocol-pending bit at bit 0 and the DMA-pending bit at bit 1. All other bits read zero, and both pending bits can be set together.
- R4: Protocol status bits 7:0 read at address 1 and bits 15:8 at address 2. A read of address 2 with nothing stacked clears the protocol status, which then holds only the conditions arriving in that cycle.
- R5: A protocol or DMA condition that arrives while its live status is non-zero is ORed into that source's stack entry, and the live status stays unchanged. A clearing read moves the stack entry into the live status.
- R6: A condition that arrives in the same cycle as a clearing read of its source is kept, either in the stack entry or in the live status.
- R7: irq_no goes low one cycle after an enabled DMA bit is pending, or after an enabled protocol bit is pending while pin_mask_i is low.
- R8: While pin_mask_i is high, a newly pending protocol interrupt leaves irq_no high but still shows as pending at address 0.
- R9: If irq_no is already low from a protocol interrupt when pin_mask_i is set, it stays low until the next read of address 2.
- R10: crc_clr_o is high for exactly the cycle after each read of address 2.
- R11: Reading the DMA status at address 3 clears only the DMA status and the DMA-pending bit. Protocol status is not affected.
- R12: Reading addresses 0, 1 or any unused address changes no state. Read data is valid while rd_i is high and reads zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prot_cond_i | input | 16 | Protocol condition pulses |
| prot_en_i | input | 16 | Protocol enable mask |
| dma_cond_i | input | 8 | DMA condition pulses |
| dma_en_i | input | 8 | DMA enable mask |
| pin_mask_i | input | 1 | Masks protocol interrupts at the pin |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 3 | Read address |
| rdata_o | output | 8 | Read data, valid in the cycle rd_i is high |
| irq_no | output | 1 | Interrupt pin, active low |
| crc_clr_o | output | 1 | One-cycle clear for the external CRC-error flag |

## Verification
A wrong stack entry does not show at the ports until the next clearing read of that source, when it appears in the reloaded status. For that reason the bench issues many clearing reads back to back and compares every read value against a queue model. A fault in the pin-hold state shows only as a one-cycle error on irq_no in the cycle after the mask changes or a pop occurs. The model therefore predicts irq_no on every clock and toggles the mask around pending interrupts. A lost same-cycle arrival shows only in the read that follows, so random traffic lets pulses coincide with reads.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 3;
  localparam int ADDR_TOP   = 0;
  localparam int ADDR_PROT0 = 1;
endpackage

// File: rtl/isc_stack_slice.sv
module isc_stack_slice #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cond_i,
  input  logic [W-1:0] en_i,
  input  logic         pop_i,
  output logic [W-1:0] live_o,
  output logic         pend_o
);
  logic [W-1:0] live_q, stk_q;
  logic         stk_v_q;
  logic         live_empty;

  assign live_empty = (live_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q  <= '0;
      stk_q   <= '0;
      stk_v_q <= 1'b0;
    end else if (pop_i) begin
      if (stk_v_q) begin
        live_q  <= stk_q;
        stk_q   <= cond_i;
        stk_v_q <= |cond_i;
      end else begin
        live_q  <= cond_i;
      end
    end else if (live_empty) begin
      live_q <= cond_i;
    end else if (|cond_i) begin
      stk_q   <= stk_q | cond_i;
      stk_v_q <= 1'b1;
    end
  end

  assign live_o = live_q;
  assign pend_o = |(live_q & en_i);

  // live status is frozen while occupied and not popped
  assert_live_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!live_empty && !pop_i) |=> live_q == $past(live_q));
  assert_pop_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && stk_v_q) |=> live_q == $past(stk_q));
  assert_same_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !stk_v_q) |=> live_q == $past(cond_i));
  assert_stack_behind_live_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_v_q |-> !live_empty);
endmodule

// File: rtl/isc_pin_ctrl.sv
module isc_pin_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic prot_pend_i,
  input  logic dma_pend_i,
  input  logic mask_i,
  input  logic prot_pop_i,
  output logic irq_no
);
  logic held_q, irq_nq, prot_drive;

  // held_q: protocol interrupt reached the pin before the mask was set
  assign prot_drive = prot_pend_i & (~mask_i | held_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      irq_nq <= 1'b1;
    end else begin
      held_q <= prot_pop_i ? 1'b0 : (held_q | (prot_pend_i & ~mask_i));
      irq_nq <= ~(dma_pend_i | prot_drive);
    end
  end

  assign irq_no = irq_nq;

  assert_mask_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i && !held_q && !dma_pend_i) |=> irq_no);
  assert_held_keeps_pin_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q && prot_pend_i) |=> !irq_no);
  assert_dma_drives_pin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_pend_i |=> !irq_no);
endmodule

// File: rtl/stacked_irq_ctrl.sv
module stacked_irq_ctrl
  import isc_pkg::*;
#(
  parameter int PROT_BYTES = 2,
  parameter int DMA_W      = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [PROT_BYTES*8-1:0] prot_cond_i,
  input  logic [PROT_BYTES*8-1:0] prot_en_i,
  input  logic [DMA_W-1:0]        dma_cond_i,
  input  logic [DMA_W-1:0]        dma_en_i,
  input  logic                    pin_mask_i,
  input  logic                    rd_i,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    irq_no,
  output logic                    crc_clr_o
);
  localparam int PROT_W   = PROT_BYTES * 8;
  localparam int POP_ADDR = ADDR_PROT0 + PROT_BYTES - 1;
  localparam int DMA_ADDR = ADDR_PROT0 + PROT_BYTES;

  logic [PROT_W-1:0] prot_live;
  logic [DMA_W-1:0]  dma_live;
  logic              prot_pend, dma_pend, prot_pop, dma_pop, crc_q;

  assign prot_pop = rd_i && (addr_i == ADDR_W'(POP_ADDR));
  assign dma_pop  = rd_i && (addr_i == ADDR_W'(DMA_ADDR));

  isc_stack_slice #(.W(PROT_W)) u_prot (
    .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(prot_cond_i), .en_i(prot_en_i),
    .pop_i(prot_pop), .live_o(prot_live), .pend_o(prot_pend));

  isc_stack_slice #(.W(DMA_W)) u_dma (
    .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(dma_cond_i), .en_i(dma_en_i),
    .pop_i(dma_pop), .live_o(dma_live), .pend_o(dma_pend));

  isc_pin_ctrl u_pin (
    .clk_i(clk_i), .rst_ni(rst_ni), .prot_pend_i(prot_pend), .dma_pend_i(dma_pend),
    .mask_i(pin_mask_i), .prot_pop_i(prot_pop), .irq_no(irq_no));

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (addr_i == ADDR_W'(ADDR_TOP))
        rdata_o = DATA_W'({dma_pend, prot_pend});
      if (addr_i == ADDR_W'(DMA_ADDR))
        rdata_o = DATA_W'(dma_live);
      for (int b = 0; b < PROT_BYTES; b++)
        if (addr_i == ADDR_W'(ADDR_PROT0 + b))
          rdata_o = prot_live[b*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_q <= 1'b0;
    else         crc_q <= prot_pop;
  end
  assign crc_clr_o = crc_q;

  assert_crc_after_pop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_pop |=> crc_clr_o);
  assert_crc_only_after_pop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prot_pop |=> !crc_clr_o);
  assert_dma_read_keeps_prot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_pop && !prot_pop && prot_live != '0) |=> prot_live == $past(prot_live));
endmodule

// File: tb/tb_stacked_irq_ctrl.sv
`timescale 1ns/1ps
module tb_stacked_irq_ctrl;
  logic        clk = 0, rst_n = 0;
  logic [15:0] pcond = 0, pen = 0;
  logic [7:0]  dcond = 0, den = 0;
  logic        mask = 0, rd = 0;
  logic [2:0]  addr = 0;
  logic [7:0]  rdata;
  logic        irq_n, crc;
  int checks = 0, errors = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  stacked_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .prot_cond_i(pcond), .prot_en_i(pen),
    .dma_cond_i(dcond), .dma_en_i(den), .pin_mask_i(mask), .rd_i(rd),
    .addr_i(addr), .rdata_o(rdata), .irq_no(irq_n), .crc_clr_o(crc));

  // reference model: queue of at most two entries per source (live, stacked)
  logic [15:0] pq[$];
  logic [15:0] dq[$];
  bit held = 0, irq_e = 1, crc_e = 0;

  function automatic bit ppend();
    return pq.size() > 0 && (pq[0] & pen) != 0;
  endfunction
  function automatic bit dpend();
    return dq.size() > 0 && (dq[0] & {8'h0, den}) != 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pq.delete(); dq.delete(); held = 0; irq_e = 1; crc_e = 0;
    end else begin
      bit pp, dp, popp, popd;
      pp = ppend(); dp = dpend();
      popp = rd && addr == 3'd2;
      popd = rd && addr == 3'd3;
      irq_e = !(dp || (pp && (!mask || held)));
      held  = popp ? 0 : (held || (pp && !mask));
      crc_e = popp;
      if (popp && pq.size() > 0) void'(pq.pop_front());
      if (pcond != 0) begin
        if (pq.size() < 2) pq.push_back(pcond);
        else pq[1] = pq[1] | pcond;
      end
      if (popd && dq.size() > 0) void'(dq.pop_front());
      if (dcond != 0) begin
        if (dq.size() < 2) dq.push_back({8'h0, dcond});
        else dq[1] = dq[1] | {8'h0, dcond};
      end
    end
  end

  function automatic logic [7:0] exp_rdata();
    if (!rd) return 8'h0;
    case (addr)
      3'd0: return {6'b0, dpend(), ppend()};
      3'd1: return pq.size() > 0 ? pq[0][7:0] : 8'h0;
      3'd2: return pq.size() > 0 ? pq[0][15:8] : 8'h0;
      3'd3: return dq.size() > 0 ? dq[0][7:0] : 8'h0;
      default: return 8'h0;
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    check({tag, " rdata"}, rdata, exp_rdata());
    check({tag, " irq_no"}, {7'b0, irq_n}, {7'b0, irq_e});
    check({tag, " crc_clr"}, {7'b0, crc}, {7'b0, crc_e});
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic pulse(logic [15:0] p, logic [7:0] d);
    pcond = p; dcond = d; step(); pcond = 0; dcond = 0;
  endtask
  task automatic rdreg(logic [2:0] a, output logic [7:0] v);
    rd = 1; addr = a; @(negedge clk); v = rdata; step(); rd = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    step(3);
    check("R1 irq_no in reset", {7'b0, irq_n}, 8'h01);
    rst_n = 1; step();
    tag = "R1";
    check("R1 irq_no", {7'b0, irq_n}, 8'h01);
    check("R1 crc_clr", {7'b0, crc}, 8'h00);
    rdreg(3'd0, v); check("R1 top", v, 8'h00);

    tag = "R2";
    pulse(16'h0008, 8'h00);
    rdreg(3'd1, v); check("R2 recorded while disabled", v, 8'h08);
    tag = "R12";
    rdreg(3'd1, v); check("R12 low byte read keeps status", v, 8'h08);
    rdreg(3'd5, v); check("R12 unused address", v, 8'h00);
    rdreg(3'd0, v); check("R2 disabled not pending", v, 8'h00);
    check("R2 pin idle", {7'b0, irq_n}, 8'h01);

    tag = "R4";
    rdreg(3'd2, v); check("R4 high byte", v, 8'h00);
    rdreg(3'd1, v); check("R4 cleared", v, 8'h00);

    tag = "R3";
    pen = 16'hffff; den = 8'hff;
    pulse(16'h0200, 8'h01);
    rdreg(3'd0, v); check("R3 both pending", v, 8'h03);
    tag = "R7";
    check("R7 pin asserted", {7'b0, irq_n}, 8'h00);

    tag = "R11";
    rdreg(3'd3, v); check("R11 dma status", v, 8'h01);
    rdreg(3'd0, v); check("R11 protocol still pending", v, 8'h01);

    tag = "R5";
    pulse(16'h0001, 8'h00);
    rdreg(3'd1, v); check("R5 live unchanged", v, 8'h00);
    rdreg(3'd2, v); check("R5 pop reports high byte", v, 8'h02);
    tag = "R10";
    check("R10 crc strobe", {7'b0, crc}, 8'h01);
    step();
    check("R10 crc one cycle", {7'b0, crc}, 8'h00);
    tag = "R5";
    rdreg(3'd1, v); check("R5 reloaded from stack", v, 8'h01);
    rdreg(3'd2, v);

    tag = "R6";
    pcond = 16'h0004; rd = 1; addr = 3'd2; step(); pcond = 0; rd = 0;
    rdreg(3'd1, v); check("R6 same-cycle arrival kept", v, 8'h04);
    rdreg(3'd2, v);

    tag = "R8";
    mask = 1;
    pulse(16'h0010, 8'h00);
    step(3);
    check("R8 masked pin", {7'b0, irq_n}, 8'h01);
    rdreg(3'd0, v); check("R8 still pending", v, 8'h01);
    rdreg(3'd2, v);
    mask = 0;
    pulse(16'h0010, 8'h00);
    step(2);
    check("R7 unmasked pin", {7'b0, irq_n}, 8'h00);
    tag = "R9";
    mask = 1; step(3);
    check("R9 held after mask", {7'b0, irq_n}, 8'h00);
    rdreg(3'd2, v); step(2);
    check("R9 released by pop", {7'b0, irq_n}, 8'h01);
    mask = 0;

    tag = "R6";
    for (int i = 0; i < 4000; i++) begin
      pcond = ($urandom_range(0, 5) == 0) ? 16'($urandom) : 16'h0;
      dcond = ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'h0;
      rd    = $urandom_range(0, 2) == 0;
      addr  = 3'($urandom_range(0, 5));
      if ($urandom_range(0, 40) == 0) mask = ~mask;
      if ($urandom_range(0, 200) == 0) pen = 16'($urandom);
      if ($urandom_range(0, 200) == 0) den = 8'($urandom);
      step();
    end
    pcond = 0; dcond = 0; rd = 0;
    step(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule